// File: doc/BRIEF.md
# Channel Status and User Bit Block Buffer

This block gathers the channel-status bit and the user bit carried by every received audio subframe and assembles them into block-sized working storage. One block spans 192 frames, each frame holding a channel A subframe followed by a channel B subframe. That gives 192 status bits per channel and 384 user bits per block. Bits are packed least-significant-bit first, so frame 0 lands in bit 0 of byte 0. When a full block has been collected, the working copy moves in one clock into a host-visible snapshot. Register reads then return that snapshot, and it does not change while the next block is being assembled.

The host reads through a simple byte port. In single-byte mode a select input picks the channel. In paired mode, successive reads inside one read burst return the channel A byte and then the channel B byte. The snapshot is not replaced while a read burst is open; the copy waits for the burst to end. The host may write status bytes into the snapshot. With reservation enabled, the first five status bytes of both channels keep the host's values across copies. A one-cycle pulse reports every completed copy so that an interrupt can be raised. A block-start marker that arrives early throws away the partial block.

Top module: `csbBlockBuf`

## Requirements
- R1: After reset, readDataOut is 0, xferDone is 0 and every snapshot byte reads as 0.
- R2: The status bit of frame f on channel A (subframe flag 0) or B (flag 1) appears after the next copy in status byte f/8, bit f%8, of that channel. Status reads use hostBufSel=0 and addresses 0 to 23.
- R3: The user bit of frame f, subframe flag s, appears after the next copy in user byte (2f+s)/8, bit (2f+s)%8. User reads use hostBufSel=1 and addresses 0 to 47.
- R4: Once the channel B subframe of frame 191 has been stored, the working data is copied into the snapshot and xferDone is high for exactly one cycle.
- R5: A block-start marker on a channel A subframe before 192 frames have arrived discards the partial block: there is no copy and no xferDone, and the marker starts a new block at frame 0.
- R6: While hostBurst is high no copy takes place and xferDone stays low. A copy that became due waits, and happens on the first clock with hostBurst low.
- R7: With cfgReserve=1, a copy leaves status bytes 0 to 4 of both channels unchanged and updates all other bytes. With cfgReserve=0, a copy replaces every byte.
- R8: A host write stores hostWdata into status byte hostAddr of the channel chosen by cfgChanSel (0=A, 1=B), and that byte reads back the written value.
- R9: With cfgTwoByte=0, a status read returns channel A when cfgChanSel=0 and channel B when cfgChanSel=1.
- R10: With cfgTwoByte=1, status reads inside one burst (hostBurst high) return A, B, A, ... for the addressed byte. Outside a burst they return A.
- R11: Read data shows up on readDataOut in the cycle after hostRd and holds until the next read.
- R12: Subframes received before the first block-start marker, and subframes that follow a completed block without a new marker, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfValid | input | 1 | One-cycle strobe per received subframe |
| sfCbit | input | 1 | Channel-status bit of the subframe |
| sfUbit | input | 1 | User bit of the subframe |
| sfChanB | input | 1 | 0 = channel A subframe, 1 = channel B |
| sfBlockStart | input | 1 | Block-start marker, honoured on channel A subframes |
| hostRd | input | 1 | Read strobe |
| hostWr | input | 1 | Write strobe (status snapshot) |
| hostBurst | input | 1 | High while a host read burst is open |
| hostBufSel | input | 1 | 0 = status bytes, 1 = user bytes |
| hostAddr | input | 6 | Byte address |
| hostWdata | input | 8 | Write data |
| cfgReserve | input | 1 | Protect status bytes 0..4 from copies |
| cfgTwoByte | input | 1 | Paired A/B read mode |
| cfgChanSel | input | 1 | Channel for single-byte reads and for writes |
| readDataOut | output | 8 | Registered read data |
| xferDone | output | 1 | One-cycle pulse per completed copy |

## Verification
The main function is driven with several blocks, each built from a different seeded bit pattern for channel A, channel B and user bits. A byte read back from a stale block, or with its channels or bit order swapped, therefore differs from the expected byte. A fixed table of reads covers the first and last bytes of each channel and of the user area. This separates channel selection from byte packing. The other patterns are a truncated block followed by a full one, extra frames after completion, a block that ends inside an open read burst, and blocks copied with reservation on and then off. They tell apart a discarded partial block, ignored stray frames, a deferred copy and a protected region from copies that happen at the wrong time.

// File: rtl/csbPkg.sv
package csbPkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             storeBit;
    logic [IDX_W-1:0] bitIdx;
    logic             isB;
    logic             xfer;
    logic             phaseB;
  } csbStrobe_t;
endpackage

// File: rtl/csbCtrl.sv
module csbCtrl
  import csbPkg::*;
#(
  parameter int FRAMES = 192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sfValid,
  input  logic       sfChanB,
  input  logic       sfBlockStart,
  input  logic       hostRd,
  input  logic       hostBurst,
  input  logic       hostBufSel,
  input  logic       cfgTwoByte,
  output csbStrobe_t strb,
  output logic       xferDone
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(FRAMES);

  logic [IDX_W-1:0] frameCnt;
  logic synced, pendingQ, phaseQ, doneQ;
  logic startNow, storeOk, completeNow, xferNow;

  always_comb begin
    startNow    = sfValid && !sfChanB && sfBlockStart;
    storeOk     = sfValid && (startNow || (synced && frameCnt < FULL));
    completeNow = storeOk && sfChanB && frameCnt == LAST;
    xferNow     = pendingQ && !hostBurst;
    strb.storeBit = storeOk;
    strb.bitIdx   = startNow ? '0 : frameCnt;
    strb.isB      = sfChanB;
    strb.xfer     = xferNow;
    strb.phaseB   = phaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      synced   <= 1'b0;
      pendingQ <= 1'b0;
      phaseQ   <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      if (startNow) begin
        synced   <= 1'b1;
        frameCnt <= '0;
      end else if (storeOk && sfChanB) begin
        frameCnt <= frameCnt + 1'b1;
      end
      if (xferNow)     pendingQ <= 1'b0;
      if (completeNow) pendingQ <= 1'b1;
      if (!hostBurst) phaseQ <= 1'b0;
      else if (hostRd && cfgTwoByte && !hostBufSel) phaseQ <= !phaseQ;
      doneQ <= xferNow;
    end
  end

  assign xferDone = doneQ;

  AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= FULL); // R12
  AST_NO_DONE_IN_BURST: assert property (@(posedge clk) disable iff (!rstN)
    hostBurst |=> !xferDone); // R6
  AST_PENDING_FROM_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendingQ) |-> $past(sfValid && sfChanB)); // R4
  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !hostBurst |=> !phaseQ); // R10
endmodule

// File: rtl/csbData.sv
module csbData
  import csbPkg::*;
#(
  parameter int FRAMES = 192,
  parameter int RSV    = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  csbStrobe_t strb,
  input  logic       sfCbit,
  input  logic       sfUbit,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic       hostBufSel,
  input  logic [$clog2(FRAMES/4)-1:0] hostAddr,
  input  logic [7:0] hostWdata,
  input  logic       cfgReserve,
  input  logic       cfgTwoByte,
  input  logic       cfgChanSel,
  output logic [7:0] readDataOut
);
  localparam int CBYTES = FRAMES / 8;
  localparam int UBYTES = 2 * FRAMES / 8;
  localparam int AW     = $clog2(UBYTES);
  localparam int CW     = $clog2(CBYTES);

  logic [FRAMES-1:0]   dCa, dCb;
  logic [2*FRAMES-1:0] dU;
  logic [7:0] eC [2][CBYTES];
  logic [7:0] eU [UBYTES];
  logic [7:0] rdQ;
  logic       rdChan;
  logic [IDX_W:0] uIdx;

  assign uIdx   = {strb.bitIdx, strb.isB};
  assign rdChan = cfgTwoByte ? strb.phaseB : cfgChanSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dCa <= '0;
      dCb <= '0;
      dU  <= '0;
    end else if (strb.storeBit) begin
      if (strb.isB) dCb[strb.bitIdx] <= sfCbit;
      else          dCa[strb.bitIdx] <= sfCbit;
      dU[uIdx] <= sfUbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < CBYTES; k++) begin
        eC[0][k] <= '0;
        eC[1][k] <= '0;
      end
      for (int k = 0; k < UBYTES; k++) eU[k] <= '0;
    end else begin
      if (strb.xfer) begin
        for (int k = 0; k < CBYTES; k++) begin
          if (!(cfgReserve && k < RSV)) begin
            eC[0][k] <= dCa[k*8 +: 8];
            eC[1][k] <= dCb[k*8 +: 8];
          end
        end
        for (int k = 0; k < UBYTES; k++) eU[k] <= dU[k*8 +: 8];
      end
      if (hostWr && hostAddr < AW'(CBYTES))
        eC[cfgChanSel][hostAddr[CW-1:0]] <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (hostRd) begin
      if (hostBufSel)
        rdQ <= (hostAddr < AW'(UBYTES)) ? eU[hostAddr] : 8'h00;
      else
        rdQ <= (hostAddr < AW'(CBYTES)) ? eC[rdChan][hostAddr[CW-1:0]] : 8'h00;
    end
  end

  assign readDataOut = rdQ;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> $stable(readDataOut)); // R11
  AST_U_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> eU[0] == $past(dU[7:0])); // R4

  for (genvar g = 0; g < RSV; g++) begin : gRsv
    AST_RSV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (strb.xfer && cfgReserve && !hostWr) |=> ($stable(eC[0][g]) && $stable(eC[1][g]))); // R7
  end
endmodule

// File: rtl/csbBlockBuf.sv
module csbBlockBuf
  import csbPkg::*;
#(
  parameter int FRAMES = 192,
  parameter int RSV    = 5,
  parameter int AW     = $clog2(FRAMES / 4)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sfValid,
  input  logic          sfCbit,
  input  logic          sfUbit,
  input  logic          sfChanB,
  input  logic          sfBlockStart,
  input  logic          hostRd,
  input  logic          hostWr,
  input  logic          hostBurst,
  input  logic          hostBufSel,
  input  logic [AW-1:0] hostAddr,
  input  logic [7:0]    hostWdata,
  input  logic          cfgReserve,
  input  logic          cfgTwoByte,
  input  logic          cfgChanSel,
  output logic [7:0]    readDataOut,
  output logic          xferDone
);
  csbStrobe_t strb;

  csbCtrl #(.FRAMES(FRAMES)) uCtrl (
    .clk(clk), .rstN(rstN), .sfValid(sfValid), .sfChanB(sfChanB),
    .sfBlockStart(sfBlockStart), .hostRd(hostRd), .hostBurst(hostBurst),
    .hostBufSel(hostBufSel), .cfgTwoByte(cfgTwoByte),
    .strb(strb), .xferDone(xferDone)
  );

  csbData #(.FRAMES(FRAMES), .RSV(RSV)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sfCbit(sfCbit), .sfUbit(sfUbit),
    .hostRd(hostRd), .hostWr(hostWr), .hostBufSel(hostBufSel),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .cfgReserve(cfgReserve),
    .cfgTwoByte(cfgTwoByte), .cfgChanSel(cfgChanSel),
    .readDataOut(readDataOut)
  );
endmodule

// File: tb/sim_csbBlockBuf.sv
module sim_csbBlockBuf;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sfValid = 0, sfCbit = 0, sfUbit = 0, sfChanB = 0, sfBlockStart = 0;
  logic hostRd = 0, hostWr = 0, hostBurst = 0, hostBufSel = 0;
  logic [5:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic cfgReserve = 0, cfgTwoByte = 0, cfgChanSel = 0;
  logic [7:0] readDataOut;
  logic xferDone;

  int checks = 0;
  int fails = 0;
  int doneCount = 0;

  always #(PERIOD/2) clk = ~clk;

  csbBlockBuf u0 (
    .clk(clk), .rstN(rstN), .sfValid(sfValid), .sfCbit(sfCbit), .sfUbit(sfUbit),
    .sfChanB(sfChanB), .sfBlockStart(sfBlockStart), .hostRd(hostRd), .hostWr(hostWr),
    .hostBurst(hostBurst), .hostBufSel(hostBufSel), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .cfgReserve(cfgReserve), .cfgTwoByte(cfgTwoByte),
    .cfgChanSel(cfgChanSel), .readDataOut(readDataOut), .xferDone(xferDone)
  );

  always @(negedge clk) if (rstN && xferDone) doneCount++;

  // bit 7 = user area, bit 6 = channel B, bits 5:0 = address
  localparam logic [7:0] RD_VEC [0:7] = '{
    8'h00, 8'h17, 8'h40, 8'h4B, 8'h57, 8'h80, 8'h98, 8'hAF
  };

  function automatic bit cBit(int s, int ch, int f);
    return ((f * (3 + ch) + s * 5) % 7) < 3;
  endfunction
  function automatic bit uBit(int s, int i);
    return ((i * (s + 2) + s) % 5) < 2;
  endfunction
  function automatic logic [7:0] expC(int s, int ch, int b);
    logic [7:0] e;
    for (int k = 0; k < 8; k++) e[k] = cBit(s, ch, b * 8 + k);
    return e;
  endfunction
  function automatic logic [7:0] expU(int s, int b);
    logic [7:0] e;
    for (int k = 0; k < 8; k++) e[k] = uBit(s, b * 8 + k);
    return e;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendSub(bit c, bit u, bit b, bit st);
    sfValid = 1; sfCbit = c; sfUbit = u; sfChanB = b; sfBlockStart = st;
    @(negedge clk);
    sfValid = 0; sfBlockStart = 0;
  endtask

  task automatic sendBlock(int s, int n, bit marker);
    for (int f = 0; f < n; f++) begin
      sendSub(cBit(s, 0, f), uBit(s, 2 * f), 1'b0, marker && f == 0);
      sendSub(cBit(s, 1, f), uBit(s, 2 * f + 1), 1'b1, 1'b0);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readByte(bit ub, int a, output logic [7:0] d);
    hostRd = 1; hostBufSel = ub; hostAddr = 6'(a);
    @(negedge clk);
    hostRd = 0;
    d = readDataOut;
  endtask

  task automatic writeByte(bit ch, int a, logic [7:0] v);
    cfgChanSel = ch; hostWr = 1; hostAddr = 6'(a); hostWdata = v;
    @(negedge clk);
    hostWr = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, held;
    int dc;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", readDataOut, 8'h00);
    check("R1 done", {7'd0, xferDone}, 8'h00);
    readByte(0, 7, d); check("R1 status byte", d, 8'h00);
    readByte(1, 30, d); check("R1 user byte", d, 8'h00);

    // R12 frames before any marker are ignored
    for (int f = 0; f < 200; f++) begin
      sendSub(1, 1, 0, 0);
      sendSub(1, 1, 1, 0);
    end
    repeat (2) @(negedge clk);
    check("R12 no copy before marker", 8'(doneCount), 8'd0);

    // R4 full block, table of reads for R2 R3 R9
    sendBlock(1, 192, 1);
    check("R4 one pulse", 8'(doneCount), 8'd1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v = RD_VEC[i];
      cfgChanSel = v[6];
      readByte(v[7], int'(v[5:0]), d);
      if (v[7]) check("R3 user byte", d, expU(1, int'(v[5:0])));
      else      check("R2 R9 status byte", d, expC(1, int'(v[6]), int'(v[5:0])));
    end
    cfgChanSel = 0;

    // R11 read data holds
    readByte(0, 9, held);
    repeat (3) @(negedge clk);
    check("R11 hold", readDataOut, held);

    // R10 paired reads
    cfgTwoByte = 1; hostBurst = 1;
    readByte(0, 3, d); check("R10 first A", d, expC(1, 0, 3));
    readByte(0, 3, d); check("R10 then B", d, expC(1, 1, 3));
    readByte(0, 3, d); check("R10 wrap A", d, expC(1, 0, 3));
    hostBurst = 0;
    @(negedge clk);
    readByte(0, 3, d); check("R10 outside burst A", d, expC(1, 0, 3));
    cfgTwoByte = 0;

    // R5 partial block discarded, marker restarts
    sendBlock(2, 100, 1);
    check("R5 no copy", 8'(doneCount), 8'd1);
    readByte(0, 20, d); check("R5 snapshot kept", d, expC(1, 0, 20));
    sendBlock(3, 192, 1);
    check("R5 restart copy", 8'(doneCount), 8'd2);
    cfgChanSel = 1;
    readByte(0, 12, d); check("R5 new block", d, expC(3, 1, 12));
    cfgChanSel = 0;

    // R12 extra frames after completion ignored
    sendBlock(4, 10, 0);
    check("R12 no extra copy", 8'(doneCount), 8'd2);

    // R6 copy deferred by burst
    hostBurst = 1;
    sendBlock(4, 192, 1);
    repeat (3) @(negedge clk);
    check("R6 deferred", 8'(doneCount), 8'd2);
    readByte(0, 15, d); check("R6 old data", d, expC(3, 0, 15));
    hostBurst = 0;
    @(negedge clk);
    check("R6 pulse after burst", {7'd0, xferDone}, 8'h01);
    readByte(1, 40, d); check("R6 copied", d, expU(4, 40));

    // R7 R8 reservation and host writes
    cfgReserve = 1;
    writeByte(0, 2, 8'hA5);
    writeByte(1, 4, 8'h3C);
    cfgChanSel = 0; readByte(0, 2, d); check("R8 write A", d, 8'hA5);
    cfgChanSel = 1; readByte(0, 4, d); check("R8 write B", d, 8'h3C);
    dc = doneCount;
    sendBlock(5, 192, 1);
    check("R4 reserve copy", 8'(doneCount - dc), 8'd1);
    cfgChanSel = 0; readByte(0, 2, d); check("R7 kept host A", d, 8'hA5);
    readByte(0, 0, d); check("R7 kept old A", d, expC(4, 0, 0));
    cfgChanSel = 1; readByte(0, 4, d); check("R7 kept host B", d, 8'h3C);
    readByte(0, 5, d); check("R7 byte5 updated", d, expC(5, 1, 5));
    cfgReserve = 0;
    sendBlock(6, 192, 1);
    cfgChanSel = 0; readByte(0, 2, d); check("R7 no reserve", d, expC(6, 0, 2));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule